// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a two-wire serial bus for a small byte-wide EEPROM. It oversamples the bus clock and data lines with a faster system clock and recognises start and stop conditions. It receives a control byte, a word address and data bytes, and answers on the data line through an open-drain style enable. It keeps the byte address pointer and runs the write, current-address read, random read and sequential read flows against an internal register array.

Each received data byte is handed to a separate page-buffer sequencer as a one-cycle write strobe with address and data. A commit pulse follows the closing stop condition of a transaction that carried data. While the sequencer reports a program cycle in progress, the engine acknowledges nothing, so a bus master can poll for completion. The storage is split into 256-byte blocks. In the default two-block build, one control-byte chip bit selects the block instead of being compared with a strap.

Top module: `eep_twi_slave`

## Requirements
- R1: After reset `sda_oe`, `pg_wr_en` and `pg_commit` are all 0.
- R2: A fall of SDA while SCL is high is a start and a rise of SDA while SCL is high is a stop. A start in the middle of a byte abandons that byte without any write and restarts control-byte reception. A stop returns the engine to idle with `sda_oe` at 0.
- R3: The control byte, sent most significant bit first, is the code 1010 in bits 7..4, then the chip field, then a direction bit in bit 0 (0 = write, 1 = read). In the default two-block build the chip field is bits 3..2 and is compared with `strap[1:0]`. Any mismatch in code or chip field gets no acknowledge, and the engine ignores the bus until the next start.
- R4: An acknowledge pulls the line low (`sda_oe` = 1) over the ninth clock and releases it at the fall that ends that clock.
- R5: After a write control byte, the next byte loads the low 8 bits of the pointer. In the two-block build, control-byte bit 1 loads pointer bit 8.
- R6: Every accepted data byte produces one single-cycle `pg_wr_en` carrying the current pointer and the byte. The byte is stored and the pointer advances.
- R7: A stop that closes a transaction with at least one accepted data byte gives exactly one `pg_commit` pulse. A stop after only control and address bytes gives none.
- R8: While `prog_busy` is 1, no byte is acknowledged, including the control byte, and no data byte is accepted.
- R9: A random read (write control byte, word address, repeated start, read control byte) returns the stored byte at that address, most significant bit first.
- R10: In a read, each byte the master acknowledges is followed by the byte at the next pointer value.
- R11: A current-address read (read control byte only) returns the byte at the pointer left by the previous operation.
- R12: The pointer wraps from the last location of a 256-byte block to the first location of the same block, on both writes and reads (0x1FF is followed by 0x100).
- R13: After the master does not acknowledge a read byte, `sda_oe` stays 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap | input | STRAP_W (2) | Chip-select strap levels compared with the control byte |
| prog_busy | input | 1 | Program cycle in progress in the page-buffer sequencer |
| pg_wr_en | output | 1 | One-cycle strobe for an accepted data byte |
| pg_wr_addr | output | ADDR_W (9) | Array address of the accepted byte |
| pg_wr_data | output | 8 | Accepted data byte |
| pg_commit | output | 1 | One-cycle pulse asking the sequencer to start programming |

## Verification
The main flows are exercised with a table of write-then-random-read pairs spread over both blocks. The table includes the block edges 0x000, 0x0FF and 0x101, so pointer bit 8 and the low address byte are each shown to reach the array. A three-byte page write starting at 0x1FE, read back sequentially, separates a correct in-block wrap from a carry into the other block. Control bytes with a wrong code, a wrong strap and a raised busy input must all be left unacknowledged, while a different block-select bit must still be acknowledged. A start injected three bits into a data byte, followed by a current-address read, shows that the abandoned byte wrote nothing and left the pointer where the word address put it.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_XMIT,
    ST_MACK,
    ST_LOAD
  } eep_state_t;

  typedef enum logic [1:0] {
    K_CTRL,
    K_WADDR,
    K_WDATA
  } eep_kind_t;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_h,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m1, scl_m2, scl_p;
  logic sda_m1, sda_m2, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m1 <= 1'b1; scl_m2 <= 1'b1; scl_p <= 1'b1;
      sda_m1 <= 1'b1; sda_m2 <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m1 <= scl_i;  scl_m2 <= scl_m1; scl_p <= scl_m2;
      sda_m1 <= sda_i;  sda_m2 <= sda_m1; sda_p <= sda_m2;
    end
  end

  assign sda_h    = sda_m2;
  assign scl_rise = scl_m2 & ~scl_p;
  assign scl_fall = ~scl_m2 & scl_p;
  assign start_ev = scl_p & scl_m2 & sda_p & ~sda_m2;
  assign stop_ev  = scl_p & scl_m2 & ~sda_p & sda_m2;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eep_twi_slave.sv
module eep_twi_slave
  import eep_pkg::*;
#(
  parameter int BLOCKS = 2,
  localparam int BLK_W   = $clog2(BLOCKS),
  localparam int ADDR_W  = 8 + BLK_W,
  localparam int STRAP_W = 3 - BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic              prog_busy,
  output logic              pg_wr_en,
  output logic [ADDR_W-1:0] pg_wr_addr,
  output logic [7:0]        pg_wr_data,
  output logic              pg_commit
);
  localparam int DEPTH = 256 * BLOCKS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic sda_h, scl_rise, scl_fall, start_ev, stop_ev;
  eep_line_sync u_sync (
    .clk(clk), .rst_n(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .sda_h(sda_h), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eep_state_t        st_q, st_d;
  eep_kind_t         kind_q, kind_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              oe_q, oe_d;
  logic              wrote_q, wrote_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              wr_en_d, commit_d;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] ptr_ctrl, ptr_waddr, ptr_inc;
  logic              addr_hit;

  // pointer variants: block bits come from the control byte when present
  generate
    if (BLK_W > 0) begin : g_blk
      assign ptr_ctrl  = {sh_q[1 +: BLK_W], ptr_q[7:0]};
      assign ptr_waddr = {ptr_q[ADDR_W-1:8], sh_q};
      assign ptr_inc   = {ptr_q[ADDR_W-1:8], ptr_q[7:0] + 8'd1};
    end else begin : g_flat
      assign ptr_ctrl  = ptr_q;
      assign ptr_waddr = sh_q;
      assign ptr_inc   = ptr_q + 8'd1;
    end
  endgenerate

  assign addr_hit = (sh_q[7:4] == DEV_CODE) && (sh_q[3 -: STRAP_W] == strap);

  eep_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_en_d), .waddr(ptr_q), .wdata(sh_q),
    .raddr(ptr_q), .rdata(rd_data)
  );

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rw_d     = rw_q;
    oe_d     = oe_q;
    wrote_d  = wrote_q;
    ptr_d    = ptr_q;
    wr_en_d  = 1'b0;
    commit_d = 1'b0;
    if (start_ev) begin
      st_d   = ST_RECV;
      kind_d = K_CTRL;
      cnt_d  = 4'd0;
      oe_d   = 1'b0;
    end else if (stop_ev) begin
      st_d     = ST_IDLE;
      oe_d     = 1'b0;
      commit_d = wrote_q;
      wrote_d  = 1'b0;
    end else begin
      case (st_q)
        ST_RECV: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_h};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            st_d = ST_IDLE;
            if (!prog_busy) begin
              case (kind_q)
                K_CTRL: begin
                  if (addr_hit) begin
                    st_d  = ST_ACK;
                    oe_d  = 1'b1;
                    rw_d  = sh_q[0];
                    ptr_d = ptr_ctrl;
                  end
                end
                K_WADDR: begin
                  st_d  = ST_ACK;
                  oe_d  = 1'b1;
                  ptr_d = ptr_waddr;
                end
                default: begin
                  st_d    = ST_ACK;
                  oe_d    = 1'b1;
                  wr_en_d = 1'b1;
                  wrote_d = 1'b1;
                  ptr_d   = ptr_inc;
                end
              endcase
            end
          end
        end
        ST_ACK, ST_LOAD: begin
          if (scl_fall) begin
            if (rw_q) begin
              st_d  = ST_XMIT;
              sh_d  = rd_data;
              oe_d  = ~rd_data[7];
              cnt_d = 4'd1;
              ptr_d = ptr_inc;
            end else begin
              st_d   = ST_RECV;
              oe_d   = 1'b0;
              cnt_d  = 4'd0;
              kind_d = (kind_q == K_CTRL) ? K_WADDR : K_WDATA;
            end
          end
        end
        ST_XMIT: begin
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              st_d = ST_MACK;
              oe_d = 1'b0;
            end else begin
              oe_d  = ~sh_q[6];
              sh_d  = {sh_q[6:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) st_d = sda_h ? ST_IDLE : ST_LOAD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_CTRL;
      cnt_q   <= 4'd0;
      sh_q    <= 8'd0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      wrote_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      wrote_q <= wrote_d;
      ptr_q   <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pg_wr_en   <= 1'b0;
      pg_commit  <= 1'b0;
      pg_wr_addr <= '0;
      pg_wr_data <= 8'd0;
    end else begin
      pg_wr_en  <= wr_en_d;
      pg_commit <= commit_d;
      if (wr_en_d) begin
        pg_wr_addr <= ptr_q;
        pg_wr_data <= sh_q;
      end
    end
  end

  assign sda_oe = oe_q;

  logic ack_phase, xmit_phase;
  assign ack_phase  = (st_q == ST_ACK);
  assign xmit_phase = (st_q == ST_XMIT);
endmodule

// File: rtl/eep_twi_chk.sv
module eep_twi_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic pg_wr_en,
  input logic pg_commit,
  input logic prog_busy,
  input logic ack_phase,
  input logic xmit_phase,
  input logic stop_ev
);
  AST_OE_IN_DRIVE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (ack_phase || xmit_phase)); // R4

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_ev) |-> !sda_oe); // R2

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wr_en |=> !pg_wr_en); // R6

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pg_commit |=> !pg_commit); // R7

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_phase) |-> !$past(prog_busy)); // R8
endmodule

bind eep_twi_slave eep_twi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .pg_wr_en(pg_wr_en),
  .pg_commit(pg_commit), .prog_busy(prog_busy), .ack_phase(ack_phase),
  .xmit_phase(xmit_phase), .stop_ev(stop_ev)
);

// File: tb/eep_twi_slave_tb.sv
module eep_twi_slave_tb_top;
  localparam int Q = 8;
  localparam logic [1:0] STRAP = 2'b10;
  // {address[8:0], data[7:0]}
  localparam logic [16:0] VEC [6] = '{
    {9'h000, 8'h3C}, {9'h0FF, 8'hA5}, {9'h101, 8'h5A},
    {9'h080, 8'h01}, {9'h1C3, 8'hFE}, {9'h055, 8'h80}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, prog_busy = 1'b0;
  logic sda_oe, pg_wr_en, pg_commit;
  logic [8:0] pg_wr_addr;
  logic [7:0] pg_wr_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, wr_cnt = 0, cm_cnt = 0;
  logic [8:0] la0 = '0, la1 = '0, la2 = '0;
  logic [7:0] ld0 = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eep_twi_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(STRAP), .prog_busy(prog_busy), .pg_wr_en(pg_wr_en),
    .pg_wr_addr(pg_wr_addr), .pg_wr_data(pg_wr_data), .pg_commit(pg_commit)
  );

  always @(posedge clk) begin
    if (pg_wr_en) begin
      wr_cnt <= wr_cnt + 1;
      la2 <= la1; la1 <= la0; la0 <= pg_wr_addr; ld0 <= pg_wr_data;
    end
    if (pg_commit) cm_cnt <= cm_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  function automatic logic [7:0] ctrl(input logic blk, input logic rd);
    return {4'b1010, STRAP, blk, rd};
  endfunction

  task automatic bus_start;
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, output bit oe_after);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = !sda_line;
    wq(); scl_m = 1'b0; wq();
    oe_after = sda_oe;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1'b1; wq(); d = {d[6:0], sda_line}; wq(); scl_m = 1'b0; wq();
    end
    send_bit(mack ? 1'b0 : 1'b1);
  endtask

  task automatic do_write(input logic [8:0] a, input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2,
                          output int acks, output bit oe_rel);
    bit k;
    logic [7:0] dd [3];
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    acks = 0;
    bus_start;
    send_byte(ctrl(a[8], 1'b0), k, oe_rel); acks += k ? 1 : 0;
    send_byte(a[7:0], k, oe_rel);           acks += k ? 1 : 0;
    for (int i = 0; i < n; i++) begin
      send_byte(dd[i], k, oe_rel); acks += k ? 1 : 0;
    end
    bus_stop; wq(2);
  endtask

  task automatic do_rread(input logic [8:0] a, input int n, output logic [7:0] q0,
                          output logic [7:0] q1, output logic [7:0] q2, output int acks);
    bit k, o;
    logic [7:0] qq [3];
    acks = 0;
    bus_start;
    send_byte(ctrl(a[8], 1'b0), k, o); acks += k ? 1 : 0;
    send_byte(a[7:0], k, o);           acks += k ? 1 : 0;
    bus_start;
    send_byte(ctrl(a[8], 1'b1), k, o); acks += k ? 1 : 0;
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, qq[i]);
    bus_stop; wq(2);
    q0 = qq[0]; q1 = qq[1]; q2 = qq[2];
  endtask

  initial begin
    int acks, c0, w0;
    bit k, o;
    logic [7:0] q0, q1, q2;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(pg_wr_en == 1'b0 && pg_commit == 1'b0, "R1 sequencer outputs idle",
        {pg_wr_en, pg_commit}, 0);
    wq(4);

    // table: single-byte write then random read of the same location
    for (int v = 0; v < 6; v++) begin
      c0 = cm_cnt;
      do_write(VEC[v][16:8], 1, VEC[v][7:0], 8'h00, 8'h00, acks, o);
      chk(acks == 3, "R3 control/address/data acknowledged", acks, 3);
      chk(o == 1'b0, "R4 line released after ack clock", o, 0);
      chk(la0 == VEC[v][16:8], "R6 strobe address", la0, VEC[v][16:8]);
      chk(ld0 == VEC[v][7:0], "R6 strobe data", ld0, VEC[v][7:0]);
      chk(cm_cnt == c0 + 1, "R7 one commit per write", cm_cnt, c0 + 1);
      do_rread(VEC[v][16:8], 1, q0, q1, q2, acks);
      chk(q0 == VEC[v][7:0] && acks == 3, "R9 R5 random read data", q0, VEC[v][7:0]);
    end

    // page write crossing the end of the upper block
    c0 = cm_cnt; w0 = wr_cnt;
    do_write(9'h1FE, 3, 8'h11, 8'h22, 8'h33, acks, o);
    chk(acks == 5, "R6 page write acks", acks, 5);
    chk(wr_cnt == w0 + 3, "R6 three strobes", wr_cnt, w0 + 3);
    chk(la2 == 9'h1FE && la1 == 9'h1FF, "R6 pointer advance", {la2, la1}, {9'h1FE, 9'h1FF});
    chk(la0 == 9'h100, "R12 write wraps inside block", la0, 9'h100);
    chk(cm_cnt == c0 + 1, "R7 single commit for page", cm_cnt, c0 + 1);
    do_rread(9'h1FE, 3, q0, q1, q2, acks);
    chk({q0, q1, q2} == 24'h112233, "R10 R12 sequential read with wrap",
        {q0, q1, q2}, 24'h112233);

    // current-address read continues from 0x101
    bus_start;
    send_byte(ctrl(1'b1, 1'b1), k, o);
    chk(k == 1'b1, "R11 read control ack", k, 1);
    recv_byte(1'b0, q0);
    wq(3);
    chk(sda_oe == 1'b0, "R13 released after master nack", sda_oe, 0);
    bus_stop; wq(2);
    chk(q0 == 8'h5A, "R11 current address data", q0, 8'h5A);

    // address mismatches
    bus_start; send_byte(8'hB8, k, o); bus_stop; wq(2);
    chk(k == 1'b0, "R3 wrong device code not acked", k, 0);
    bus_start; send_byte({4'b1010, ~STRAP, 2'b00}, k, o); bus_stop; wq(2);
    chk(k == 1'b0, "R3 wrong strap not acked", k, 0);
    bus_start; send_byte(ctrl(1'b0, 1'b0), k, o); bus_stop; wq(2);
    chk(k == 1'b1, "R3 block bit is not compared", k, 1);

    // busy: nothing acknowledged, then polling succeeds
    prog_busy = 1'b1; w0 = wr_cnt;
    do_write(9'h010, 1, 8'h77, 8'h00, 8'h00, acks, o);
    chk(acks == 0, "R8 no ack while busy", acks, 0);
    chk(wr_cnt == w0, "R8 no strobe while busy", wr_cnt, w0);
    prog_busy = 1'b0;
    bus_start; send_byte(ctrl(1'b0, 1'b0), k, o); bus_stop; wq(2);
    chk(k == 1'b1, "R8 ack after busy clears", k, 1);

    // stop with address only: no commit
    c0 = cm_cnt;
    do_write(9'h000, 0, 8'h00, 8'h00, 8'h00, acks, o);
    chk(acks == 2 && cm_cnt == c0, "R7 no commit without data", cm_cnt, c0);

    // start three bits into a data byte abandons it
    w0 = wr_cnt;
    bus_start;
    send_byte(ctrl(1'b0, 1'b0), k, o);
    send_byte(8'h00, k, o);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    bus_start;
    send_byte(ctrl(1'b0, 1'b1), k, o);
    recv_byte(1'b0, q0);
    bus_stop; wq(2);
    chk(wr_cnt == w0, "R2 aborted byte not written", wr_cnt, w0);
    chk(k == 1'b1 && q0 == 8'h3C, "R2 restart after mid-byte start", q0, 8'h3C);
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule